// File: doc/BRIEF.md
# Transmit Heartbeat Monitor and Collision Test Injector

This block watches each transmit attempt of an Ethernet MAC. It records whether the attempt collided and passes that result to a small retry counter. After an attempt that ended cleanly, it can open a heartbeat window. The window lasts a fixed number of transmit clock ticks. During it the block waits for the transceiver to pulse its collision line as a signal-quality heartbeat. If the pulse does not come, a heartbeat-missing status bit is set for the frame.

A test mode makes every attempt count as collided and drives a collision request toward a looped-back transceiver. This exercises the retry path until the programmable retry limit is exceeded and the frame is dropped. The mode is meant only for loopback operation. Backoff timing and the transmit datapath live elsewhere. A new-frame strobe clears the retry count and the heartbeat status.

Top module: `tx_sqe_monitor`

## Requirements
- R1: While reset is held and on the first cycle after it, every output is low and the retry count is 0.
- R2: With heartbeat checking off, an attempt end opens no window: `hb_busy_o` stays low and `hb_missing_o` is never set.
- R3: With heartbeat checking on, an accepted attempt end that did not collide raises `hb_busy_o` on the next cycle. The window then stays open for exactly 20 cycles on which `tx_ce` is high. A collided attempt opens no window.
- R4: If the window runs out with no collision seen, `hb_missing_o` goes high at the window close. It stays high until the next `frame_start` or reset.
- R5: A high `col_in` on any clock while the window is open closes it at once without setting `hb_missing_o`. This includes the clock that carries the 20th tick.
- R6: A `tx_done` strobe that arrives while the window is open is ignored. It produces no collision indication, leaves the retry count unchanged, and does not restart or stretch the window.
- R7: An attempt is collided when `col_in` was high together with `tx_active` on any cycle of the attempt, including the `tx_done` cycle. The cycle after `tx_done`, `col_ind_o` pulses high for one cycle and the retry count rises by one.
- R8: With force-collision on, `force_col_o` follows `tx_active` one cycle later. Every attempt is reported collided, whatever `col_in` does.
- R9: A collided attempt that finds the retry count already equal to `retry_limit` pulses `retry_exceeded_o` together with `col_ind_o` and returns the count to 0. With a limit of 15 and force-collision on, this happens on the 16th attempt of a frame.
- R10: `frame_start` returns the retry count to 0 and clears `hb_missing_o` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_ce | input | 1 | Transmit clock tick enable |
| tx_active | input | 1 | High while an attempt is being sent |
| tx_done | input | 1 | One-cycle strobe: attempt finished |
| frame_start | input | 1 | One-cycle strobe: a new frame begins |
| col_in | input | 1 | Collision line from the transceiver |
| hb_check_en | input | 1 | Heartbeat checking mode |
| force_col_en | input | 1 | Force-collision loopback test mode |
| retry_limit | input | 4 | Collisions allowed before the frame is dropped |
| force_col_o | output | 1 | Collision request toward the looped-back transceiver |
| col_ind_o | output | 1 | One-cycle collided-attempt indication |
| retry_cnt_o | output | 4 | Collided attempts counted for the current frame |
| retry_exceeded_o | output | 1 | One-cycle pulse: retry limit exceeded, frame dropped |
| hb_busy_o | output | 1 | Heartbeat window open |
| hb_missing_o | output | 1 | Heartbeat not heard for this frame |

## Verification
The bench places the window's edges precisely. A design with an off-by-one tick counter shows up at tick 19 or tick 20. A heartbeat that lands exactly on the 20th tick must still count as heard, or the status bit would be set wrongly. When the transmit tick runs at half rate, a design that counts clocks instead of ticks closes the window early.

A second `tx_done` inside an open window must leave everything untouched. A design that accepts it would restart the window, pulse a collision or bump the count. Under forced collisions the bench drives sixteen attempts and also uses a small limit. A comparator that is off by one fires the exceeded pulse one attempt early or late, and a missing wrap leaves the count stuck.

// File: rtl/sqe_pkg.sv
package sqe_pkg;

    // transmit clock ticks the heartbeat window stays open
    localparam int HB_TICKS_DEF = 20;
    // width of the retry count and of the limit input
    localparam int RETRY_W_DEF  = 4;

    typedef enum logic [0:0] {
        HB_IDLE = 1'b0,
        HB_WAIT = 1'b1
    } hb_state_t;

    // result of one accepted transmit attempt
    typedef struct packed {
        logic done;
        logic collided;
    } attempt_t;

    function automatic logic attempt_collided(
        input logic seen,
        input logic col,
        input logic active,
        input logic force_on
    );
        return seen | (col & active) | force_on;
    endfunction

    function automatic logic limit_reached(
        input logic [RETRY_W_DEF-1:0] cnt,
        input logic [RETRY_W_DEF-1:0] limit
    );
        return cnt >= limit;
    endfunction

endpackage

// File: rtl/sqe_attempt_track.sv
module sqe_attempt_track
    import sqe_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tx_active,
    input  logic     tx_done,
    input  logic     col_in,
    input  logic     force_col_en,
    input  logic     hb_busy,
    output attempt_t evt,
    output logic     force_col
);

    logic coll_seen;
    logic accept;

    // a done strobe only counts when no heartbeat window is pending
    assign accept       = tx_done & ~hb_busy;
    assign evt.done     = accept;
    assign evt.collided = accept &
                          attempt_collided(coll_seen, col_in, tx_active, force_col_en);

    always_ff @(posedge clk) begin
        if (rst) begin
            coll_seen <= 1'b0;
            force_col <= 1'b0;
        end else begin
            force_col <= force_col_en & tx_active;
            if (tx_done) begin
                coll_seen <= 1'b0;
            end else if (col_in & tx_active) begin
                coll_seen <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/sqe_hb_window.sv
module sqe_hb_window
    import sqe_pkg::*;
#(
    parameter int HB_TICKS = HB_TICKS_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic open_req,
    input  logic col_in,
    input  logic clear,
    output logic busy,
    output logic missing
);

    localparam int CNT_W = (HB_TICKS > 1) ? $clog2(HB_TICKS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HB_TICKS - 1);

    hb_state_t        state;
    logic [CNT_W-1:0] ticks;

    assign busy = (state == HB_WAIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= HB_IDLE;
            ticks   <= '0;
            missing <= 1'b0;
        end else begin
            if (clear) begin
                missing <= 1'b0;
            end
            case (state)
                HB_IDLE: begin
                    if (open_req) begin
                        state <= HB_WAIT;
                        ticks <= '0;
                    end
                end
                HB_WAIT: begin
                    if (col_in) begin
                        state <= HB_IDLE;
                    end else if (tick) begin
                        if (ticks == LAST) begin
                            state <= HB_IDLE;
                            if (!clear) begin
                                missing <= 1'b1;
                            end
                        end else begin
                            ticks <= ticks + 1'b1;
                        end
                    end
                end
                default: state <= HB_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sqe_retry_count.sv
module sqe_retry_count
    import sqe_pkg::*;
#(
    parameter int RETRY_W = RETRY_W_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  attempt_t           evt,
    input  logic               frame_start,
    input  logic [RETRY_W-1:0] limit,
    output logic [RETRY_W-1:0] cnt,
    output logic               col_ind,
    output logic               exceeded
);

    logic hit;

    assign hit = evt.done & evt.collided;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            col_ind  <= 1'b0;
            exceeded <= 1'b0;
        end else begin
            col_ind  <= hit;
            exceeded <= 1'b0;
            if (hit) begin
                if (cnt >= limit) begin
                    exceeded <= 1'b1;
                    cnt      <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
            if (frame_start) begin
                cnt <= '0;
            end
        end
    end

endmodule

// File: rtl/tx_sqe_monitor.sv
module tx_sqe_monitor
    import sqe_pkg::*;
#(
    parameter int HB_TICKS = HB_TICKS_DEF,
    parameter int RETRY_W  = RETRY_W_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tx_ce,
    input  logic               tx_active,
    input  logic               tx_done,
    input  logic               frame_start,
    input  logic               col_in,
    input  logic               hb_check_en,
    input  logic               force_col_en,
    input  logic [RETRY_W-1:0] retry_limit,
    output logic               force_col_o,
    output logic               col_ind_o,
    output logic [RETRY_W-1:0] retry_cnt_o,
    output logic               retry_exceeded_o,
    output logic               hb_busy_o,
    output logic               hb_missing_o
);

    attempt_t evt;
    logic     hb_busy;
    logic     open_req;

    assign open_req  = evt.done & ~evt.collided & hb_check_en;
    assign hb_busy_o = hb_busy;

    sqe_attempt_track u_track (
        .clk          (clk),
        .rst          (rst),
        .tx_active    (tx_active),
        .tx_done      (tx_done),
        .col_in       (col_in),
        .force_col_en (force_col_en),
        .hb_busy      (hb_busy),
        .evt          (evt),
        .force_col    (force_col_o)
    );

    sqe_hb_window #(.HB_TICKS(HB_TICKS)) u_window (
        .clk      (clk),
        .rst      (rst),
        .tick     (tx_ce),
        .open_req (open_req),
        .col_in   (col_in),
        .clear    (frame_start),
        .busy     (hb_busy),
        .missing  (hb_missing_o)
    );

    sqe_retry_count #(.RETRY_W(RETRY_W)) u_retry (
        .clk         (clk),
        .rst         (rst),
        .evt         (evt),
        .frame_start (frame_start),
        .limit       (retry_limit),
        .cnt         (retry_cnt_o),
        .col_ind     (col_ind_o),
        .exceeded    (retry_exceeded_o)
    );

endmodule

// File: rtl/tx_sqe_monitor_chk.sv
module tx_sqe_monitor_chk #(
    parameter int RETRY_W = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               tx_done,
    input logic               frame_start,
    input logic               hb_check_en,
    input logic               force_col_en,
    input logic               col_ind_o,
    input logic [RETRY_W-1:0] retry_cnt_o,
    input logic               retry_exceeded_o,
    input logic               hb_busy_o,
    input logic               hb_missing_o
);

    // R4
    missing_from_window_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(hb_missing_o) |-> $past(hb_busy_o));

    // R9
    exceeded_with_col_chk: assert property (@(posedge clk) disable iff (rst)
        retry_exceeded_o |-> (col_ind_o && retry_cnt_o == '0));

    // R10
    frame_clear_chk: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> (!hb_missing_o && retry_cnt_o == '0));

    // R6
    done_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_done && hb_busy_o) |=> !col_ind_o);

    // R8
    forced_col_chk: assert property (@(posedge clk) disable iff (rst)
        (force_col_en && tx_done && !hb_busy_o) |=> col_ind_o);

    // R2
    no_window_chk: assert property (@(posedge clk) disable iff (rst)
        (!hb_check_en && tx_done && !hb_busy_o) |=> !hb_busy_o);

endmodule

bind tx_sqe_monitor tx_sqe_monitor_chk #(.RETRY_W(RETRY_W)) u_chk (
    .clk              (clk),
    .rst              (rst),
    .tx_done          (tx_done),
    .frame_start      (frame_start),
    .hb_check_en      (hb_check_en),
    .force_col_en     (force_col_en),
    .col_ind_o        (col_ind_o),
    .retry_cnt_o      (retry_cnt_o),
    .retry_exceeded_o (retry_exceeded_o),
    .hb_busy_o        (hb_busy_o),
    .hb_missing_o     (hb_missing_o)
);

// File: tb/test_tx_sqe_monitor.sv
module test_tx_sqe_monitor;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tx_ce = 1'b1;
    logic       tx_active = 1'b0;
    logic       tx_done = 1'b0;
    logic       frame_start = 1'b0;
    logic       col_in = 1'b0;
    logic       hb_check_en = 1'b0;
    logic       force_col_en = 1'b0;
    logic [3:0] retry_limit = 4'd15;
    logic       force_col_o;
    logic       col_ind_o;
    logic [3:0] retry_cnt_o;
    logic       retry_exceeded_o;
    logic       hb_busy_o;
    logic       hb_missing_o;

    int  checks = 0;
    int  errors = 0;
    bit  ce_half = 1'b0;
    bit  finished = 1'b0;

    always #2 clk = ~clk;

    tx_sqe_monitor i_tx_sqe_monitor (
        .clk              (clk),
        .rst              (rst),
        .tx_ce            (tx_ce),
        .tx_active        (tx_active),
        .tx_done          (tx_done),
        .frame_start      (frame_start),
        .col_in           (col_in),
        .hb_check_en      (hb_check_en),
        .force_col_en     (force_col_en),
        .retry_limit      (retry_limit),
        .force_col_o      (force_col_o),
        .col_ind_o        (col_ind_o),
        .retry_cnt_o      (retry_cnt_o),
        .retry_exceeded_o (retry_exceeded_o),
        .hb_busy_o        (hb_busy_o),
        .hb_missing_o     (hb_missing_o)
    );

    task automatic tick();
        @(posedge clk);
        #1;
        if (ce_half) tx_ce = ~tx_ce;
    endtask

    task automatic check(string req, string what, int actual, int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, actual, expected);
        end
    endtask

    task automatic new_frame();
        frame_start = 1'b1;
        tick();
        frame_start = 1'b0;
    endtask

    // sends one attempt; after return the outputs of the done edge are visible
    task automatic attempt(int len, bit col_mid);
        tx_active = 1'b1;
        for (int i = 0; i < len; i++) begin
            col_in = col_mid && (i == len / 2);
            tick();
        end
        col_in  = 1'b0;
        tx_done = 1'b1;
        tick();
        tx_done   = 1'b0;
        tx_active = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 100 && hb_busy_o; i++) tick();
    endtask

    task automatic t_reset();
        check("R1", "busy", hb_busy_o, 0);
        check("R1", "missing", hb_missing_o, 0);
        check("R1", "col_ind", col_ind_o, 0);
        check("R1", "exceeded", retry_exceeded_o, 0);
        check("R1", "force", force_col_o, 0);
        check("R1", "count", retry_cnt_o, 0);
    endtask

    task automatic t_hb_off();
        hb_check_en = 1'b0;
        new_frame();
        attempt(3, 0);
        check("R2", "busy after done", hb_busy_o, 0);
        repeat (25) tick();
        check("R2", "missing", hb_missing_o, 0);
    endtask

    task automatic t_hb_heard();
        hb_check_en = 1'b1;
        new_frame();
        attempt(3, 0);
        check("R3", "window opens", hb_busy_o, 1);
        check("R3", "no col_ind", col_ind_o, 0);
        repeat (5) tick();
        col_in = 1'b1;
        tick();
        col_in = 1'b0;
        check("R5", "window closed by heartbeat", hb_busy_o, 0);
        check("R5", "missing stays low", hb_missing_o, 0);
    endtask

    task automatic t_hb_missing();
        hb_check_en = 1'b1;
        new_frame();
        attempt(3, 0);
        repeat (19) tick();
        check("R3", "open after 19 ticks", hb_busy_o, 1);
        check("R4", "missing not yet", hb_missing_o, 0);
        tick();
        check("R3", "closed after 20 ticks", hb_busy_o, 0);
        check("R4", "missing set", hb_missing_o, 1);
        repeat (3) tick();
        check("R4", "missing held", hb_missing_o, 1);
        new_frame();
        check("R10", "missing cleared", hb_missing_o, 0);
    endtask

    task automatic t_hb_last_tick();
        hb_check_en = 1'b1;
        new_frame();
        attempt(3, 0);
        repeat (19) tick();
        col_in = 1'b1;
        tick();
        col_in = 1'b0;
        check("R5", "heard on 20th tick busy", hb_busy_o, 0);
        check("R5", "heard on 20th tick missing", hb_missing_o, 0);
    endtask

    task automatic t_half_rate();
        int n = 0;
        hb_check_en = 1'b1;
        new_frame();
        attempt(3, 0);
        ce_half = 1'b1;
        for (int i = 0; i < 100 && hb_busy_o; i++) begin
            if (tx_ce) n++;
            tick();
        end
        ce_half = 1'b0;
        tx_ce   = 1'b1;
        check("R3", "ticks counted at half rate", n, 20);
        check("R4", "missing at half rate", hb_missing_o, 1);
    endtask

    task automatic t_done_ignored();
        int c0;
        hb_check_en = 1'b1;
        new_frame();
        attempt(3, 0);
        c0 = retry_cnt_o;
        repeat (9) tick();
        tx_done = 1'b1;
        tick();
        tx_done = 1'b0;
        check("R6", "no col_ind", col_ind_o, 0);
        check("R6", "count same", retry_cnt_o, c0);
        repeat (9) tick();
        check("R6", "still open at tick 19", hb_busy_o, 1);
        tick();
        check("R6", "closes at original tick 20", hb_busy_o, 0);
        check("R6", "missing", hb_missing_o, 1);
    endtask

    task automatic t_real_collision();
        hb_check_en = 1'b1;
        force_col_en = 1'b0;
        new_frame();
        attempt(4, 1);
        check("R7", "col_ind pulse", col_ind_o, 1);
        check("R7", "count", retry_cnt_o, 1);
        check("R3", "no window on collided attempt", hb_busy_o, 0);
        tick();
        check("R7", "col_ind one cycle", col_ind_o, 0);
        attempt(3, 0);
        check("R7", "clean attempt no col_ind", col_ind_o, 0);
        check("R7", "count kept", retry_cnt_o, 1);
        wait_idle();
        new_frame();
        check("R10", "count cleared", retry_cnt_o, 0);
    endtask

    task automatic t_force(int lim);
        hb_check_en  = 1'b1;
        force_col_en = 1'b1;
        retry_limit  = 4'(lim);
        new_frame();
        tx_active = 1'b1;
        tick();
        check("R8", "force follows tx_active", force_col_o, 1);
        tx_active = 1'b0;
        tick();
        check("R8", "force drops", force_col_o, 0);
        for (int i = 0; i <= lim; i++) begin
            attempt(2, 0);
            check("R8", "forced col_ind", col_ind_o, 1);
            check("R9", "exceeded", retry_exceeded_o, (i == lim) ? 1 : 0);
            check("R9", "count", retry_cnt_o, (i == lim) ? 0 : i + 1);
            check("R8", "no window", hb_busy_o, 0);
            tick();
            check("R9", "exceeded one cycle", retry_exceeded_o, 0);
        end
        force_col_en = 1'b0;
        retry_limit  = 4'd15;
    endtask

    initial begin
        repeat (3) tick();
        check("R1", "busy in reset", hb_busy_o, 0);
        rst = 1'b0;
        tick();
        t_reset();
        t_hb_off();
        t_hb_heard();
        t_hb_missing();
        t_hb_last_tick();
        t_half_rate();
        t_done_ignored();
        t_real_collision();
        t_force(15);
        t_force(2);
        t_force(0);
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule